// File: doc/BRIEF.md
# Sixteen-by-sixteen plane-mode intra predictor

This block builds the plane-mode prediction for one 16x16 luma macroblock. It takes the sixteen reconstructed pixels above the block, the sixteen to its left and the single corner pixel above-left. From these it derives the horizontal and vertical gradients, then streams out all 256 clipped predictor values. A `start` pulse in the idle state captures the neighbour pixels. Two setup cycles follow, one for the gradient sums and one for the slope, offset and first-row seed values. The prediction then leaves the block as 64 beats of four pixels each.

Four lane accumulators produce the pixels. Each one holds a signed linear value and moves one column by adding the horizontal slope, so no multiplier sits in the per-pixel path. In each row the lanes start at columns 0, 8, 4 and 12 and cover four adjacent columns each. At a row change the row base gains the vertical slope and all four lanes are loaded again. The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low the beat is held unchanged, and the block advances only on a cycle where both are high. Once the final beat has been accepted, a single-cycle `done` pulse follows.

Top module: `plane_pred16`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid` and `done` are 0. A reset during a stream abandons it.
- R2: In the idle state, a `start` sampled high at a rising edge makes `out_valid` go high after the second rising edge that follows. The pixel inputs are captured only at that sampling edge.
- R3: Top pixel column x is `top_px[8x+7:8x]`, left pixel row y is `left_px[8y+7:8y]`, and the corner is index -1 in both lines. Each output pixel equals clip(((a + b*(x-7) + c*(y-7) + 16) >>> 5)). The terms are: a = 16*(left[15]+top[15]), b = (5*H+32)>>>6, c = (5*V+32)>>>6, H = sum over i=0..7 of (i+1)*(top[8+i]-top[6-i]), and V is the same sum over the left line.
- R4: Results below 0 are output as 0, and results above 255 are output as 255.
- R5: Beat n carries row n/4 on `out_row` and column n%4 on `out_col`. Beats come in row-major order, 64 per block. Inside the beat, `out_pix[7:0]` holds column `out_col`, `[15:8]` holds `out_col`+8, `[23:16]` holds `out_col`+4, and `[31:24]` holds `out_col`+12.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_pix`, `out_row` and `out_col` unchanged.
- R7: `done` is high for exactly the one cycle after the 64th beat is accepted, and `out_valid` is low in that cycle.
- R8: A `start` that arrives while the block is busy is ignored. Changes to the pixel inputs after capture have no effect on the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a macroblock; honoured only when idle |
| top_px | input | 128 | Sixteen pixels above the block, column 0 in the low byte |
| left_px | input | 128 | Sixteen pixels left of the block, row 0 in the low byte |
| corner_px | input | 8 | Pixel above-left of the block |
| out_valid | output | 1 | Beat on the output is valid |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_pix | output | 32 | Four predicted pixels, lane order as in R5 |
| out_row | output | 4 | Row of the current beat |
| out_col | output | 4 | Column of lane 0 in the current beat (0..3) |
| done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The stream assertions depend on the consumer alone driving `out_ready`. They also assume that `out_ready` may change freely, with no requirement to hold it. The bench therefore draws `out_ready` from several random densities, including always-high and mostly-low. The pixel checks assume neighbour values in 0..255 and an input that can change at any time after `start`. To cover this, every run scrambles the inputs right after capture, and one run also raises `start` in the middle of its stream. The table entries use monotonic ramps chosen so that both clip limits are reached.

// File: rtl/plane_pkg.sv
package plane_pkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_GRAD,
    PS_PARM,
    PS_RUN
  } pstate_e;

  // First column of a lane: lane index bit-reversed, scaled by the lane span.
  function automatic int seed_col(input int k, input int bits, input int span);
    int r;
    r = 0;
    for (int j = 0; j < bits; j++)
      if (((k >> j) & 1) != 0) r = r | (1 << (bits - 1 - j));
    return r * span;
  endfunction

endpackage

// File: rtl/plane_grad.sv
module plane_grad #(
  parameter int PIX_W  = 8,
  parameter int N      = 16,
  parameter int GRAD_W = 15
) (
  input  logic [N*PIX_W-1:0]       line,
  input  logic [PIX_W-1:0]         corner,
  output logic signed [GRAD_W-1:0] grad
);
  localparam int HALF = N / 2;

  // ext[0] is the corner, ext[j+1] is line pixel j
  logic [PIX_W-1:0] ext [N+1];

  always_comb begin
    ext[0] = corner;
    for (int j = 0; j < N; j++) ext[j+1] = line[j*PIX_W +: PIX_W];
  end

  always_comb begin
    logic signed [GRAD_W-1:0] diff;
    grad = '0;
    for (int i = 0; i < HALF; i++) begin
      diff = GRAD_W'($signed({1'b0, ext[HALF+1+i]}))
           - GRAD_W'($signed({1'b0, ext[HALF-1-i]}));
      grad = grad + diff * GRAD_W'(i + 1);
    end
  end
endmodule

// File: rtl/plane_lane.sv
module plane_lane #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 20,
  parameter int FRAC  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] seed_val,
  input  logic signed [ACC_W-1:0] inc,
  output logic [PIX_W-1:0]        pix
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] scaled;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= seed_val;
    else if (step) acc_q <= acc_q + inc;
  end

  always_comb begin
    scaled = acc_q >>> FRAC;
    if (scaled < 0)         pix = '0;
    else if (scaled > MAXV) pix = '1;
    else                    pix = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/plane_pred16.sv
module plane_pred16
  import plane_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int ACC_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [16*PIX_W-1:0]      top_px,
  input  logic [16*PIX_W-1:0]      left_px,
  input  logic [PIX_W-1:0]         corner_px,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*PIX_W-1:0]   out_pix,
  output logic [3:0]               out_row,
  output logic [3:0]               out_col,
  output logic                     done
);
  localparam int N         = 16;
  localparam int HALF      = N / 2;
  localparam int STEPS     = N / LANES;
  localparam int STEP_W    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int GRAD_W    = PIX_W + 7;
  localparam int FRAC      = 5;
  localparam logic [3:0]        ROW_LAST = 4'(N - 1);
  localparam logic [STEP_W-1:0] COL_LAST = STEP_W'(STEPS - 1);
  localparam logic signed [ACC_W-1:0] K_GAIN = 5;
  localparam logic signed [ACC_W-1:0] K_RBC  = 32;
  localparam logic signed [ACC_W-1:0] K_RND  = 16;
  localparam logic signed [ACC_W-1:0] K_OFF  = ACC_W'(HALF - 1);

  pstate_e                 st_q;
  logic [N*PIX_W-1:0]      top_q, left_q;
  logic [PIX_W-1:0]        corner_q;
  logic signed [GRAD_W-1:0] h_q, v_q, h_n, v_n;
  logic signed [ACC_W-1:0] b_q, c_q, base_q;
  logic [3:0]              row_q;
  logic [STEP_W-1:0]       col_q;
  logic                    done_q;

  // Gradient sums over the captured lines
  plane_grad #(.PIX_W(PIX_W), .N(N), .GRAD_W(GRAD_W)) u_grad_h (
    .line(top_q), .corner(corner_q), .grad(h_n));
  plane_grad #(.PIX_W(PIX_W), .N(N), .GRAD_W(GRAD_W)) u_grad_v (
    .line(left_q), .corner(corner_q), .grad(v_n));

  // Slopes, offset and the seed of row 0 column 0 (rounding folded in)
  logic signed [ACC_W-1:0] hx, vx, b_n, c_n, a_n, base0;
  logic [PIX_W:0]          edge_sum;

  always_comb begin
    hx       = {{(ACC_W-GRAD_W){h_q[GRAD_W-1]}}, h_q};
    vx       = {{(ACC_W-GRAD_W){v_q[GRAD_W-1]}}, v_q};
    b_n      = (hx * K_GAIN + K_RBC) >>> 6;
    c_n      = (vx * K_GAIN + K_RBC) >>> 6;
    edge_sum = {1'b0, left_q[(N-1)*PIX_W +: PIX_W]} + {1'b0, top_q[(N-1)*PIX_W +: PIX_W]};
    a_n      = {{(ACC_W-PIX_W-5){1'b0}}, edge_sum, 4'b0000};
    base0    = a_n + K_RND - K_OFF * b_n - K_OFF * c_n;
  end

  logic fire, last_col, last_row, lane_load, lane_step;
  logic signed [ACC_W-1:0] base_sel, b_sel;

  assign fire      = (st_q == PS_RUN) && out_ready;
  assign last_col  = (col_q == COL_LAST);
  assign last_row  = (row_q == ROW_LAST);
  assign base_sel  = (st_q == PS_PARM) ? base0 : base_q + c_q;
  assign b_sel     = (st_q == PS_PARM) ? b_n : b_q;
  assign lane_load = (st_q == PS_PARM) || (fire && last_col && !last_row);
  assign lane_step = fire && !last_col;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int SEED = seed_col(k, LANE_BITS, STEPS);
    localparam logic signed [ACC_W-1:0] SEED_S = ACC_W'(SEED);
    logic signed [ACC_W-1:0] seed_val;
    assign seed_val = base_sel + SEED_S * b_sel;

    plane_lane #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(lane_load), .step(lane_step),
      .seed_val(seed_val), .inc(b_q), .pix(out_pix[k*PIX_W +: PIX_W]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= PS_IDLE;
      top_q    <= '0;
      left_q   <= '0;
      corner_q <= '0;
      h_q      <= '0;
      v_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      base_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        PS_IDLE: if (start) begin
          top_q    <= top_px;
          left_q   <= left_px;
          corner_q <= corner_px;
          st_q     <= PS_GRAD;
        end
        PS_GRAD: begin
          h_q  <= h_n;
          v_q  <= v_n;
          st_q <= PS_PARM;
        end
        PS_PARM: begin
          b_q    <= b_n;
          c_q    <= c_n;
          base_q <= base0;
          row_q  <= '0;
          col_q  <= '0;
          st_q   <= PS_RUN;
        end
        PS_RUN: if (out_ready) begin
          if (!last_col) begin
            col_q <= col_q + 1'b1;
          end else begin
            col_q <= '0;
            if (last_row) begin
              st_q   <= PS_IDLE;
              done_q <= 1'b1;
            end else begin
              row_q  <= row_q + 4'd1;
              base_q <= base_q + c_q;
            end
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign out_valid = (st_q == PS_RUN);
  assign out_row   = row_q;
  assign out_col   = {{(4-STEP_W){1'b0}}, col_q};
  assign done      = done_q;
endmodule

// File: rtl/plane_pred16_chk.sv
module plane_pred16_chk #(
  parameter int PIX_W = 8,
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*PIX_W-1:0] out_pix,
  input logic [3:0]             out_row,
  input logic [3:0]             out_col,
  input logic                   done
);
  localparam logic [3:0] COL_LAST = 4'(16 / LANES - 1);

  // R6: a stalled beat stays put
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pix) && $stable(out_row) && $stable(out_col)));

  // R5: column advance inside a row
  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_col != COL_LAST) |=>
      (out_valid && out_row == $past(out_row) && out_col == $past(out_col) + 4'd1));

  // R5: row wrap
  assert_row_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_col == COL_LAST && out_row != 4'd15) |=>
      (out_valid && out_col == 4'd0 && out_row == $past(out_row) + 4'd1));

  // R7: last accepted beat ends the stream with done
  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_col == COL_LAST && out_row == 4'd15) |=>
      (done && !out_valid));

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind plane_pred16 plane_pred16_chk #(.PIX_W(PIX_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix), .out_row(out_row), .out_col(out_col), .done(done));

// File: tb/plane_pred16_test.sv
module plane_pred16_test;
  localparam int PW = 8;
  localparam int LN = 4;
  localparam int N  = 16;
  localparam int LIMIT = 100000;
  localparam int SEEDS [LN] = '{0, 8, 4, 12};
  // corner, top0, top step, left0, left step, exp(0,0), exp(y15,x0), exp(15,15)
  localparam int VEC [5][8] = '{
    '{100, 100,  0, 100,  0, 100, 100, 100},
    '{  0,   0,  0,   0,  0,   0,   0,   0},
    '{255, 255,  0, 255,  0, 255, 255, 255},
    '{ 32,  40,  8,  40,  8,  48, 168, 255},
    '{168, 160, -8, 160, -8, 152,  32,   0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [N*PW-1:0] top_px = '0, left_px = '0;
  logic [PW-1:0]   corner_px = '0;
  logic            out_valid, done;
  logic [LN*PW-1:0] out_pix;
  logic [3:0]      out_row, out_col;

  always #10 clk = ~clk;

  plane_pred16 uut (
    .clk(clk), .rst_n(rst_n), .start(start), .top_px(top_px), .left_px(left_px),
    .corner_px(corner_px), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_row(out_row), .out_col(out_col), .done(done));

  int errors = 0, checks = 0, cycles = 0;
  int tp [N];
  int lf [N];
  int cr;
  int obs [N][N];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int y, input int x);
    int h, v, a, b, c, p, lo;
    h = 0; v = 0;
    for (int i = 0; i < 8; i++) begin
      lo = (i == 7) ? cr : tp[6-i];
      h += (i + 1) * (tp[8+i] - lo);
      lo = (i == 7) ? cr : lf[6-i];
      v += (i + 1) * (lf[8+i] - lo);
    end
    a = 16 * (lf[15] + tp[15]);
    b = (5 * h + 32) >>> 6;
    c = (5 * v + 32) >>> 6;
    p = (a + b * (x - 7) + c * (y - 7) + 16) >>> 5;
    if (p < 0) p = 0;
    if (p > 255) p = 255;
    return p;
  endfunction

  task automatic pack_inputs();
    for (int j = 0; j < N; j++) begin
      top_px[j*PW +: PW]  = PW'(tp[j]);
      left_px[j*PW +: PW] = PW'(lf[j]);
    end
    corner_px = PW'(cr);
  endtask

  task automatic scramble();
    for (int j = 0; j < N; j++) begin
      top_px[j*PW +: PW]  = PW'($urandom_range(0, 255));
      left_px[j*PW +: PW] = PW'($urandom_range(0, 255));
    end
    corner_px = PW'($urandom_range(0, 255));
  endtask

  // rmode: 0 always ready, 1 half, 2 sparse. disturb: start pulse mid-stream
  task automatic run_mb(input int rmode, input bit disturb);
    int beat, row, s, act, exp, guard;
    bit rdy, poked;
    @(negedge clk);
    pack_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();   // R8: inputs after capture must not matter
    check(!out_valid, "R2 valid early (1)", out_valid, 0);
    @(negedge clk);
    check(!out_valid, "R2 valid early (2)", out_valid, 0);
    @(negedge clk);
    check(out_valid, "R2 valid after setup", out_valid, 1);
    beat = 0; guard = 0; poked = 1'b0;
    while (beat < 64 && guard < 2000) begin
      guard++;
      start = 1'b0;
      if (out_valid) begin
        row = beat / 4; s = beat % 4;
        check(out_row == 4'(row) && out_col == 4'(s), "R5 beat position",
              int'({out_row, out_col}), (row << 4) | s);
        for (int k = 0; k < LN; k++) begin
          act = int'(out_pix[k*PW +: PW]);
          exp = model(row, s + SEEDS[k]);
          obs[row][s + SEEDS[k]] = act;
          check(act == exp, "R3 R6 lane pixel", act, exp);
        end
        case (rmode)
          0: rdy = 1'b1;
          1: rdy = ($urandom_range(0, 1) == 1);
          default: rdy = ($urandom_range(0, 3) == 0);
        endcase
        out_ready = rdy;
        if (disturb && !poked && beat == 20) begin
          start = 1'b1;
          scramble();
          poked = 1'b1;
        end
        if (rdy) beat++;
      end else begin
        check(1'b0, "R6 valid dropped mid-stream", 0, 1);
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    start = 1'b0;
    check(done && !out_valid, "R7 done after last beat", int'({done, out_valid}), 2);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    @(negedge clk);
    @(negedge clk);
    check(!out_valid, "R8 no stray restart", out_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= LIMIT) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R1 reset outputs", int'({out_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !done, "R1 first cycle out of reset", int'({out_valid, done}), 0);

    // Table of ramps and flats, with hand-derived corner pixels
    for (int v = 0; v < 5; v++) begin
      cr = VEC[v][0];
      for (int j = 0; j < N; j++) begin
        tp[j] = VEC[v][1] + VEC[v][2] * j;
        lf[j] = VEC[v][3] + VEC[v][4] * j;
      end
      run_mb(v % 3, 1'b0);
      check(obs[0][0] == VEC[v][5], "R3 R4 table pixel(0,0)", obs[0][0], VEC[v][5]);
      check(obs[15][0] == VEC[v][6], "R3 R4 table pixel(15,0)", obs[15][0], VEC[v][6]);
      check(obs[15][15] == VEC[v][7], "R4 table pixel(15,15)", obs[15][15], VEC[v][7]);
    end

    // Random neighbourhoods, different consumer densities, busy start
    for (int r = 0; r < 4; r++) begin
      cr = $urandom_range(0, 255);
      for (int j = 0; j < N; j++) begin
        tp[j] = $urandom_range(0, 255);
        lf[j] = $urandom_range(0, 255);
      end
      run_mb(r % 3, r >= 2);
    end

    // Extreme gradients: steep clip on both ends
    cr = 255;
    for (int j = 0; j < N; j++) begin
      tp[j] = (j < 8) ? 255 : 0;
      lf[j] = (j < 8) ? 0 : 255;
    end
    run_mb(0, 1'b1);

    // Reset during a stream
    @(negedge clk);
    pack_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    out_ready = 1'b1;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && !done, "R1 reset mid-stream", int'({out_valid, done}), 0);
    rst_n = 1'b1;
    out_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(!out_valid, "R1 stream abandoned", out_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule